// File: doc/BRIEF.md
# Half-Screen Line Splitter

This block takes a video stream that carries two neighbouring pixels of a line on every clock and turns it into two streams of half the width. On every output clock one stream gives pixel i of the left half of the line and the other gives pixel i of the right half. The block keeps exactly one line of storage. Each output line is the input line before it, so the delay is one line plus one clock.

Storage is a single dual-port pixel memory that is used in place. Both ports read a location and write it again in the same cycle, and each read returns the value the location held before the write. The outputs are read in a different order from the one in which the inputs are written. For this reason the mapping from logical pixel position to physical address changes from line to line. The mapping uses position `LINE_W-1` as a fixed point. Every other position m of a line sits at address (m * stride) mod (`LINE_W-1`). At each line boundary the stride is halved modulo `LINE_W-1`, which is the same as multiplying it by `LINE_W/2`. The per-pixel path needs only adders and conditional subtracts, with no multiplier.

Top module: `stripe_splitter`

## Requirements
- R1: While reset is held and on the first falling edge after it is released, `out_valid`, `out_sof` and `out_eol` are all 0.
- R2: After reset no output is valid until the input has completed one whole line of `LINE_W/2` accepted pairs.
- R3: From the second line of a frame on, `out_valid` is 1 exactly one clock after each cycle in which `in_valid` is 1, and 0 one clock after each cycle in which `in_valid` is 0.
- R4: On the output belonging to input pair k (counted from 0) of a line, `out_left` equals pixel k of the previous line and `out_right` equals pixel k+`LINE_W/2` of that line. Within a line, pixel 2k arrives on `in_px_a` of pair k and pixel 2k+1 arrives on `in_px_b`. The two write addresses of a cycle always differ.
- R5: The R4 pixel relation holds for every line over many consecutive lines. Each of those lines uses a different physical address permutation.
- R6: Idle cycles with `in_valid` at 0 may fall anywhere in a line. They change neither the pixel order nor the pair count.
- R7: A pair accepted with `in_sof` at 1 is pair 0 of line 0 of a new frame. Any partially received line is dropped. The line that `in_sof` starts produces no valid output.
- R8: `out_sof` is 1 only on the output that belongs to pair 0 of line 1 of a frame, and always together with `out_valid`.
- R9: `out_eol` is 1 only on a valid output that belongs to the last pair (k = `LINE_W/2`-1) of a line.
- R10: Streaming continues without a gap after more than `FRAME_H` lines with no `in_sof`. The line counter saturates, and R4 keeps holding.
- R11: An `in_sof` accepted on the pair that would otherwise end a line wins over the line end. The stride restarts at 1 and the outputs for that line stay invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pair present this cycle |
| in_sof | input | 1 | Input pair is the first of a frame |
| in_px_a | input | PIX_W | Even pixel 2k of the pair |
| in_px_b | input | PIX_W | Odd pixel 2k+1 of the pair |
| out_valid | output | 1 | Both output pixels valid |
| out_sof | output | 1 | First output pair of a frame |
| out_eol | output | 1 | Last output pair of a line |
| out_left | output | PIX_W | Left-half pixel k of the previous line |
| out_right | output | PIX_W | Right-half pixel k+LINE_W/2 of the previous line |

## Verification
Two events compete for the same cycle. One is a frame restart through `in_sof`. The other is a line boundary, which steps the stride and bumps the line counter. The bench provokes the clash directly: it sends `LINE_W/2-1` pairs and then raises `in_sof` on the pair that would close the line. It then expects one blank line followed by output that matches the restarted frame. Random start-of-frame pulses and random idle cycles are mixed into long runs, and a bench model of line halves, delayed by one line, judges every valid output.

// File: rtl/stripe_pkg.sv
package stripe_pkg;
   typedef struct packed {
      logic valid;
      logic sof;
      logic eol;
   } stripe_sync_t;

   localparam stripe_sync_t SYNC_IDLE = '{valid: 1'b0, sof: 1'b0, eol: 1'b0};
endpackage

// File: rtl/stripe_addr_gen.sv
module stripe_addr_gen #(
   parameter int LINE_W = 3840,
   parameter int AW     = $clog2(LINE_W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   input  logic          sof,
   input  logic          last,
   output logic [AW-1:0] addr0,
   output logic [AW-1:0] addr1
);
   localparam int          MODV  = LINE_W - 1;
   localparam logic [AW-1:0] MOD_A = AW'(MODV);
   localparam logic [AW-1:0] ONE_A = AW'(1);
   localparam logic [AW-1:0] TWO_A = AW'(2 % MODV);

   logic [AW-1:0] stride_q, step2_q, base_q;
   logic [AW-1:0] stride_e, step2_e, base_e;
   logic [AW:0]   sum_b, sum_n, odd_sum;
   logic [AW-1:0] b_mod, n_mod, stride_half;

   always_comb begin
      stride_e = sof ? ONE_A : stride_q;
      step2_e  = sof ? TWO_A : step2_q;
      base_e   = sof ? '0    : base_q;

      sum_b = {1'b0, base_e} + {1'b0, stride_e};
      b_mod = (sum_b >= {1'b0, MOD_A}) ? AW'(sum_b - {1'b0, MOD_A}) : sum_b[AW-1:0];

      sum_n = {1'b0, base_e} + {1'b0, step2_e};
      n_mod = (sum_n >= {1'b0, MOD_A}) ? AW'(sum_n - {1'b0, MOD_A}) : sum_n[AW-1:0];

      odd_sum     = {1'b0, stride_e} + {1'b0, MOD_A};
      stride_half = stride_e[0] ? odd_sum[AW:1] : {1'b0, stride_e[AW-1:1]};

      addr0 = base_e;
      addr1 = last ? MOD_A : b_mod;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stride_q <= ONE_A;
         step2_q  <= TWO_A;
         base_q   <= '0;
      end else if (fire) begin
         if (last) begin
            stride_q <= stride_half;
            step2_q  <= stride_e;
            base_q   <= '0;
         end else begin
            stride_q <= stride_e;
            step2_q  <= step2_e;
            base_q   <= n_mod;
         end
      end
   end
endmodule

// File: rtl/stripe_line_mem.sv
module stripe_line_mem #(
   parameter int DEPTH   = 3840,
   parameter int AW      = $clog2(DEPTH),
   parameter int PIX_W   = 24,
   parameter int RD_PIPE = 0
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    a0,
   input  logic [AW-1:0]    a1,
   input  logic [PIX_W-1:0] d0,
   input  logic [PIX_W-1:0] d1,
   output logic [PIX_W-1:0] q0,
   output logic [PIX_W-1:0] q1
);
   logic [PIX_W-1:0] store [DEPTH];
   logic [PIX_W-1:0] r0, r1;

   always_ff @(posedge clk) begin
      r0 <= store[a0];
      r1 <= store[a1];
      if (we) begin
         store[a0] <= d0;
         store[a1] <= d1;
      end
   end

   generate
      if (RD_PIPE != 0) begin : g_pipe
         logic [PIX_W-1:0] p0, p1;
         always_ff @(posedge clk) begin
            p0 <= r0;
            p1 <= r1;
         end
         assign q0 = p0;
         assign q1 = p1;
      end else begin : g_direct
         assign q0 = r0;
         assign q1 = r1;
      end
   endgenerate
endmodule

// File: rtl/stripe_seq.sv
module stripe_seq
   import stripe_pkg::*;
#(
   parameter int HALF    = 1920,
   parameter int FRAME_H = 2400,
   parameter int RD_PIPE = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         in_sof,
   output logic         last,
   output stripe_sync_t sync_out
);
   localparam int KW = (HALF > 1) ? $clog2(HALF) : 1;
   localparam int LW = $clog2(FRAME_H + 1);
   localparam logic [KW-1:0] K_LAST = KW'(HALF - 1);
   localparam logic [LW-1:0] L_MAX  = LW'(FRAME_H);

   logic [KW-1:0] pair_q, pair_e;
   logic [LW-1:0] line_q, line_e;
   stripe_sync_t  s0_q, s0_d;

   always_comb begin
      pair_e = in_sof ? '0 : pair_q;
      line_e = in_sof ? '0 : line_q;
      last   = (pair_e == K_LAST);
      s0_d.valid = in_valid && (line_e != '0);
      s0_d.sof   = in_valid && (line_e == LW'(1)) && (pair_e == '0);
      s0_d.eol   = in_valid && (line_e != '0) && last;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pair_q <= '0;
         line_q <= '0;
         s0_q   <= SYNC_IDLE;
      end else begin
         s0_q <= s0_d;
         if (in_valid) begin
            if (last) begin
               pair_q <= '0;
               line_q <= (line_e == L_MAX) ? L_MAX : line_e + LW'(1);
            end else begin
               pair_q <= pair_e + KW'(1);
               line_q <= line_e;
            end
         end
      end
   end

   generate
      if (RD_PIPE != 0) begin : g_pipe
         stripe_sync_t s1_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s1_q <= SYNC_IDLE;
            else        s1_q <= s0_q;
         end
         assign sync_out = s1_q;
      end else begin : g_direct
         assign sync_out = s0_q;
      end
   endgenerate
endmodule

// File: rtl/stripe_splitter.sv
module stripe_splitter
   import stripe_pkg::*;
#(
   parameter int LINE_W  = 3840,
   parameter int FRAME_H = 2400,
   parameter int PIX_W   = 24,
   parameter int RD_PIPE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic [PIX_W-1:0] in_px_a,
   input  logic [PIX_W-1:0] in_px_b,
   output logic             out_valid,
   output logic             out_sof,
   output logic             out_eol,
   output logic [PIX_W-1:0] out_left,
   output logic [PIX_W-1:0] out_right
);
   localparam int HALF = LINE_W / 2;
   localparam int AW   = $clog2(LINE_W);

   generate
      if ((LINE_W % 2) != 0 || LINE_W < 4) begin : g_bad_width
         $error("stripe_splitter: LINE_W must be even and at least 4");
      end
      if (FRAME_H < 2) begin : g_bad_height
         $error("stripe_splitter: FRAME_H must be at least 2");
      end
      if (RD_PIPE != 0 && RD_PIPE != 1) begin : g_bad_pipe
         $error("stripe_splitter: RD_PIPE must be 0 or 1");
      end
   endgenerate

   logic          last_pair;
   logic [AW-1:0] wa0, wa1;
   stripe_sync_t  sync_w;

   stripe_seq #(.HALF(HALF), .FRAME_H(FRAME_H), .RD_PIPE(RD_PIPE)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_sof   (in_sof),
      .last     (last_pair),
      .sync_out (sync_w)
   );

   stripe_addr_gen #(.LINE_W(LINE_W), .AW(AW)) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (in_valid),
      .sof   (in_sof),
      .last  (last_pair),
      .addr0 (wa0),
      .addr1 (wa1)
   );

   stripe_line_mem #(.DEPTH(LINE_W), .AW(AW), .PIX_W(PIX_W), .RD_PIPE(RD_PIPE)) u_mem (
      .clk (clk),
      .we  (in_valid),
      .a0  (wa0),
      .a1  (wa1),
      .d0  (in_px_a),
      .d1  (in_px_b),
      .q0  (out_left),
      .q1  (out_right)
   );

   assign out_valid = sync_w.valid;
   assign out_sof   = sync_w.sof;
   assign out_eol   = sync_w.eol;
endmodule

// File: rtl/stripe_splitter_chk.sv
module stripe_splitter_chk #(
   parameter int LINE_W = 3840,
   parameter int AW     = $clog2(LINE_W),
   parameter int LAT    = 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_sof,
   input logic          out_valid,
   input logic          out_sof,
   input logic          out_eol,
   input logic [AW-1:0] wa0,
   input logic [AW-1:0] wa1
);
   localparam logic [AW-1:0] MOD_A = AW'(LINE_W - 1);

   logic [LAT-1:0] vpipe, spipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vpipe <= '0;
         spipe <= '0;
      end else begin
         vpipe[0] <= in_valid;
         spipe[0] <= in_valid && in_sof;
         for (int i = 1; i < LAT; i++) begin
            vpipe[i] <= vpipe[i-1];
            spipe[i] <= spipe[i-1];
         end
      end
   end

   p_valid_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> vpipe[LAT-1]);

   p_sof_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
      spipe[LAT-1] |-> !out_valid);

   p_sof_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid);

   p_eol_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_eol |-> out_valid);

   p_addr_distinct_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (wa0 != wa1));

   p_addr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (wa0 < MOD_A && wa1 <= MOD_A));
endmodule

bind stripe_splitter stripe_splitter_chk #(
   .LINE_W (LINE_W),
   .AW     ($clog2(LINE_W)),
   .LAT    (1 + RD_PIPE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_sof    (in_sof),
   .out_valid (out_valid),
   .out_sof   (out_sof),
   .out_eol   (out_eol),
   .wa0       (wa0),
   .wa1       (wa1)
);

// File: tb/sim_stripe_splitter.sv
module sim_stripe_splitter;
   localparam int CLK_PERIOD = 10;
   localparam int LINE_W  = 16;
   localparam int HALF    = LINE_W / 2;
   localparam int FRAME_H = 5;
   localparam int PIX_W   = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_sof = 1'b0;
   logic [PIX_W-1:0] in_px_a = '0, in_px_b = '0;
   logic out_valid, out_sof, out_eol;
   logic [PIX_W-1:0] out_left, out_right;

   int checks = 0;
   int errors = 0;

   logic [PIX_W-1:0] prev_ln [LINE_W];
   logic [PIX_W-1:0] cur_ln  [LINE_W];
   int m_pair = 0;
   int m_line = 0;
   logic e_valid = 1'b0, e_sof = 1'b0, e_eol = 1'b0;
   logic [PIX_W-1:0] e_left = '0, e_right = '0;
   logic e_last_sof = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stripe_splitter #(.LINE_W(LINE_W), .FRAME_H(FRAME_H), .PIX_W(PIX_W), .RD_PIPE(0)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_px_a(in_px_a), .in_px_b(in_px_b), .out_valid(out_valid),
      .out_sof(out_sof), .out_eol(out_eol), .out_left(out_left), .out_right(out_right)
   );

   task automatic chk(input string req, input logic [PIX_W-1:0] act, input logic [PIX_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_prev();
      chk(e_last_sof ? "R7 valid" : (e_valid ? "R3 valid" : "R2 valid"),
          PIX_W'(out_valid), PIX_W'(e_valid));
      chk("R8 sof", PIX_W'(out_sof), PIX_W'(e_sof));
      chk("R9 eol", PIX_W'(out_eol), PIX_W'(e_eol));
      if (e_valid) begin
         chk("R4 left", out_left, e_left);
         chk("R5 right", out_right, e_right);
      end
   endtask

   task automatic step(input logic v, input logic s);
      logic [PIX_W-1:0] pa, pb;
      @(negedge clk);
      check_prev();
      pa = PIX_W'($urandom);
      pb = PIX_W'($urandom);
      in_valid = v; in_sof = s; in_px_a = pa; in_px_b = pb;
      e_last_sof = v && s;
      if (v) begin
         if (s) begin m_pair = 0; m_line = 0; end
         e_valid = (m_line >= 1);
         e_sof   = (m_line == 1) && (m_pair == 0);
         e_eol   = e_valid && (m_pair == HALF-1);
         e_left  = prev_ln[m_pair];
         e_right = prev_ln[m_pair + HALF];
         cur_ln[2*m_pair]   = pa;
         cur_ln[2*m_pair+1] = pb;
         if (m_pair == HALF-1) begin
            for (int i = 0; i < LINE_W; i++) prev_ln[i] = cur_ln[i];
            m_pair = 0;
            m_line++;
         end else m_pair++;
      end else begin
         e_valid = 1'b0; e_sof = 1'b0; e_eol = 1'b0;
      end
   endtask

   task automatic send_lines(input int n, input int stall_pct, input logic first_sof);
      for (int l = 0; l < n; l++) begin
         for (int k = 0; k < HALF; k++) begin
            while (($urandom % 100) < stall_pct) step(1'b0, 1'b0);
            step(1'b1, first_sof && l == 0 && k == 0);
         end
      end
   endtask

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < LINE_W; i++) begin prev_ln[i] = '0; cur_ln[i] = '0; end
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", PIX_W'(out_valid), '0);
      chk("R1 sof in reset", PIX_W'(out_sof), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 eol after reset", PIX_W'(out_eol), '0);
      chk("R1 valid after reset", PIX_W'(out_valid), '0);
      // R2, R4, R5: continuous lines, no frame start
      send_lines(4, 0, 1'b0);
      // R6: idle cycles inside lines
      send_lines(4, 30, 1'b0);
      // R7: frame restart mid-line
      for (int k = 0; k < 3; k++) step(1'b1, 1'b0);
      send_lines(3, 10, 1'b1);
      // R11: restart on the pair that would close a line
      for (int k = 0; k < HALF-1; k++) step(1'b1, 1'b0);
      send_lines(3, 0, 1'b1);
      // R10: run well past FRAME_H lines
      send_lines(FRAME_H + 3, 5, 1'b1);
      // random mix of stalls and restarts
      for (int r = 0; r < 600; r++) begin
         logic v, s;
         v = ($urandom % 100) < 75;
         s = v && (($urandom % 100) < 2);
         step(v, s);
      end
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule